// File: doc/BRIEF.md
# Shared Interrupt Level Aggregator

This block merges the level-sensitive interrupt pins of many bus devices into a small set of shared interrupt lines. Every device slot has four interrupt pins. The block keeps the last level seen on each pin. When a pin really changes level, it adds +1 or -1 to a counter that belongs to the shared line the pin is routed to. A shared line is high whenever its counter is not zero. The line therefore acts as the OR of every source routed to it, and the design never has to OR a wide input vector.

Pin levels come in as one flat vector. Bit `4*slot + pin` carries the level of pin `pin` (0 to 3) of device slot `slot`. Each shared line is registered, so it follows the pin levels that were sampled at the previous rising clock edge. The number of device slots and the number of shared lines are parameters.

Top module: `irq_share_agg`

## Requirements
- R1: When `rst` is high at a rising edge, every counter and every stored pin level is cleared, and `line_out` reads all zeros from the next edge on. A pin held high through reset counts as a new assertion on the first edge after reset is released.
- R2: Pin `p` of slot `s` (input bit `4*s+p`) is routed to shared line `(s + p) mod NUM_LINES`, and to no other line.
- R3: A shared line is high exactly when at least one source routed to it is high, and its counter never goes below zero.
- R4: `line_out` changes at the first rising edge after the input change that causes it, and not earlier.
- R5: Holding a pin at its stored level changes no counter, and `line_out` stays stable while no pin changes.
- R6: All pin changes that arrive in the same cycle are applied together. A rise and a fall on the same line cancel, and several rises on one line add up.
- R7: A counter never overflows, even when all `NUM_SLOTS*4` sources are high and are then released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | NUM_SLOTS*4 | Device pin levels, bit 4*slot+pin |
| line_out | output | NUM_LINES | Registered shared interrupt lines |

## Verification
Two events can fall in the same cycle: one source on a line rises while another source on the same line falls, and several sources on one line change in the same step. The bench drives both cases on purpose. In one step, slot 0 pin 1 falls while slot 1 pin 0 rises, and the line must stay high. In another, both pins on that line rise together and then fall one at a time, and the line must stay high until the last one falls. The random phase toggles several bits per cycle, so it also produces many mixed changes in one cycle on shared lines. Every cycle is judged against a bench function that ORs the routed pins.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

  localparam int PINS_PER_SLOT = 4;

  // Shared line that a given slot pin is routed to.
  function automatic int route_line(input int slot, input int pin, input int lines);
    return (slot + pin) % lines;
  endfunction

  // Bits needed to count up to max_val inclusive.
  function automatic int count_bits(input int max_val);
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int SRC = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SRC-1:0] pin_lvl,
  output logic [SRC-1:0] stored_lvl,
  output logic [SRC-1:0] rise_ev,
  output logic [SRC-1:0] fall_ev
);

  logic [SRC-1:0] stored_q;

  always_ff @(posedge clk) begin
    if (rst) stored_q <= '0;
    else     stored_q <= pin_lvl;
  end

  // A real transition is a difference from the stored level.
  always_comb begin
    rise_ev = pin_lvl & ~stored_q;
    fall_ev = ~pin_lvl & stored_q;
  end

  assign stored_lvl = stored_q;

  AST_STORE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stored_lvl == $past(pin_lvl))); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (stored_lvl == '0)); // R1

endmodule

// File: rtl/irq_line_delta.sv
module irq_line_delta
  import irq_share_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_LINES = 4,
  parameter int DW        = 9
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] rise_ev,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] fall_ev,
  output logic [NUM_LINES*DW-1:0]            delta_flat
);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic signed [DW-1:0] acc;

    always_comb begin
      acc = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < PINS_PER_SLOT; p++) begin
          if (route_line(s, p, NUM_LINES) == l) begin
            if (rise_ev[s*PINS_PER_SLOT + p]) acc = acc + DW'(1);
            if (fall_ev[s*PINS_PER_SLOT + p]) acc = acc - DW'(1);
          end
        end
      end
    end

    assign delta_flat[l*DW +: DW] = acc;
  end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int CW      = 8,
  parameter int DW      = 9,
  parameter int MAX_SRC = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] delta,
  output logic [CW-1:0]        cnt_o,
  output logic                 line_o
);

  logic [CW-1:0]        cnt_q;
  logic                 line_q;
  logic signed [DW:0]   sum_w;
  logic [CW-1:0]        cnt_d;
  logic                 underflow_w;
  logic                 overflow_w;

  always_comb begin
    sum_w       = $signed({2'b00, cnt_q}) + $signed({delta[DW-1], delta});
    cnt_d       = sum_w[CW-1:0];
    underflow_w = sum_w[DW];
    overflow_w  = !sum_w[DW] && (sum_w > $signed((DW+1)'(MAX_SRC)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      line_q <= (cnt_d != '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign line_o = line_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !underflow_w); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !overflow_w); // R7

  AST_LINE_IS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    line_o == (cnt_o != '0)); // R3

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (delta == '0) |=> $stable(line_o)); // R5

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
  import irq_share_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_LINES = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_lvl,
  output logic [NUM_LINES-1:0]               line_out
);

  localparam int SRC = NUM_SLOTS * PINS_PER_SLOT;
  localparam int CW  = count_bits(SRC);
  localparam int DW  = CW + 1;

  logic [SRC-1:0]           stored_lvl;
  logic [SRC-1:0]           rise_ev;
  logic [SRC-1:0]           fall_ev;
  logic [NUM_LINES*DW-1:0]  delta_flat;
  logic [NUM_LINES*CW-1:0]  cnt_flat;

  irq_pin_tracker #(.SRC(SRC)) u_track (
    .clk        (clk),
    .rst        (rst),
    .pin_lvl    (pin_lvl),
    .stored_lvl (stored_lvl),
    .rise_ev    (rise_ev),
    .fall_ev    (fall_ev)
  );

  irq_line_delta #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_LINES (NUM_LINES),
    .DW        (DW)
  ) u_delta (
    .rise_ev    (rise_ev),
    .fall_ev    (fall_ev),
    .delta_flat (delta_flat)
  );

  // Reference count of stored high sources routed to one line.
  function automatic logic [CW-1:0] routed_high(input logic [SRC-1:0] lv, input int line);
    logic [CW-1:0] n;
    n = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < PINS_PER_SLOT; p++)
        if (route_line(s, p, NUM_LINES) == line && lv[s*PINS_PER_SLOT + p])
          n = n + CW'(1);
    return n;
  endfunction

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
    irq_line_counter #(
      .CW      (CW),
      .DW      (DW),
      .MAX_SRC (SRC)
    ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .delta  (delta_flat[l*DW +: DW]),
      .cnt_o  (cnt_flat[l*CW +: CW]),
      .line_o (line_out[l])
    );

    AST_CNT_TRACKS_PINS: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[l*CW +: CW] == routed_high(stored_lvl, l)); // R6
  end

endmodule

// File: tb/irq_share_agg_tb_top.sv
`timescale 1ns/1ps
module irq_share_agg_tb_top;

  localparam int NS  = 32;
  localparam int NL  = 4;
  localparam int SRC = NS * 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [SRC-1:0] pins = '0;
  logic [NL-1:0]  line_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  irq_share_agg #(.NUM_SLOTS(NS), .NUM_LINES(NL)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .pin_lvl  (pins),
    .line_out (line_out)
  );

  // Expected lines: OR over sources routed by (slot + pin) mod lines.
  function automatic logic [NL-1:0] want_lines(input logic [SRC-1:0] v);
    logic [NL-1:0] w;
    w = '0;
    for (int i = 0; i < SRC; i++)
      if (v[i]) w[((i / 4) + (i % 4)) % NL] = 1'b1;
    return w;
  endfunction

  function automatic logic [SRC-1:0] one_pin(input int slot, input int pin);
    logic [SRC-1:0] v;
    v = '0;
    v[slot*4 + pin] = 1'b1;
    return v;
  endfunction

  task automatic check(input logic [NL-1:0] exp, input string req);
    total++;
    if (line_out !== exp) begin
      bad++;
      $display("FAIL %s: line_out=%b expected=%b", req, line_out, exp);
    end
  endtask

  // Called at a falling edge: apply, wait one edge, check.
  task automatic drive_chk(input logic [SRC-1:0] nxt, input string req);
    pins = nxt;
    @(negedge clk);
    check(want_lines(nxt), req);
  endtask

  initial begin
    logic [SRC-1:0] v;
    void'($urandom(32'h1F2E3D4C));
    // R1: reset with all sources high keeps lines low
    pins = '1;
    repeat (3) @(negedge clk);
    check('0, "R1 lines low in reset");
    rst = 1'b0;
    #1 check('0, "R4 no change before edge");
    @(negedge clk);
    check('1, "R1 held-high pins count after reset");
    // R7: all sources high then all released
    drive_chk('0, "R7 all released");
    drive_chk('1, "R7 all asserted");
    drive_chk('0, "R7 all released again");
    // R2: mapping of single pins
    drive_chk(one_pin(5, 2), "R2 slot5 pin2 to line3");
    drive_chk(one_pin(31, 3), "R2 slot31 pin3 to line2");
    drive_chk(one_pin(0, 0), "R2 slot0 pin0 to line0");
    drive_chk(one_pin(6, 3), "R2 slot6 pin3 to line1");
    // R4: new level not visible before the edge
    pins = one_pin(2, 0);
    #1 check(4'b0010, "R4 old value held until edge");
    @(negedge clk);
    check(4'b0100, "R4 new value after one edge");
    // R5: holding levels changes nothing
    for (int k = 0; k < 4; k++) drive_chk(one_pin(2, 0), "R5 hold stable");
    // R6: rise and fall on the same line in one cycle
    drive_chk(one_pin(0, 1), "R6 setup line1");
    drive_chk(one_pin(1, 0), "R6 swap sources on line1");
    drive_chk(one_pin(0, 1) | one_pin(1, 0), "R6 two on line1");
    drive_chk('0, "R6 both fall");
    drive_chk(one_pin(0, 1) | one_pin(1, 0) | one_pin(2, 3), "R6 three rise together");
    drive_chk(one_pin(1, 0) | one_pin(2, 3), "R6 one of three falls");
    drive_chk(one_pin(2, 3), "R6 two of three fall");
    drive_chk('0, "R6 last falls");
    // R1: reset mid-run with sources high
    pins = one_pin(3, 1) | one_pin(9, 2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check('0, "R1 mid-run reset clears lines");
    rst = 1'b0;
    @(negedge clk);
    check(want_lines(pins), "R1 recount after reset");
    // R3: random toggles of a few bits each cycle
    v = pins;
    for (int n = 0; n < 400; n++) begin
      int flips;
      flips = $urandom_range(0, 5);
      for (int f = 0; f < flips; f++) v[$urandom_range(0, SRC-1)] ^= 1'b1;
      drive_chk(v, "R3 random OR of routed sources");
    end
    drive_chk('0, "R3 final release");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule